// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames arriving one byte per beat on a stream with an end-of-frame flag. It places each frame into host memory through a simple memory master port. Before storing a frame it fetches the four-word descriptor at its current ring pointer and checks that the engine owns it. It then packs the frame bytes little-endian into the buffer that the descriptor names. Once all data is in memory, it writes the stored length and an error flag into the first descriptor word, which clears the ownership bit in the same write. After that it follows the chain link, or steps to the adjacent descriptor, to reach the next one.

Software controls the block through a small register port with three registers. One enables reception. One holds the ring start address, and writing it reloads the engine's descriptor pointer. The third is a status register whose bits are cleared by writing one. A completed frame raises the normal-summary bit, and that bit drives the interrupt output. A frame that arrives while the current descriptor belongs to the host is drained from the stream and discarded, and a separate "no buffer" status bit records the loss.

Top module: `rxring_writer`

## Requirements
- R1: After reset, all three registers read as zero, `s_ready`, `mem_req` and `irq` are low.
- R2: While the enable bit (register 0, bit 0) is clear, the engine issues no memory request and never raises `s_ready`, even with `s_valid` held high.
- R3: When a frame starts, the engine reads descriptor words 0..3 at the current pointer. Word 0 bit 31 set means the engine owns the descriptor. Word 1 bits 12:0 give the buffer size in bytes. Word 2 is the word-aligned buffer address.
- R4: If word 0 bit 31 is clear, the whole frame is consumed and dropped. Nothing is written to memory, status bit 1 is set, status bit 2 stays clear, and the pointer does not move, so the next frame uses the same descriptor.
- R5: Frame byte n goes to buffer address + n. Bytes are packed little-endian into 32-bit words, a partial last word is written with only its valid byte enables, and memory past the stored bytes is left untouched.
- R6: Bytes beyond the buffer size are discarded. The stored length equals the buffer size, and word 0 bit 0 (error) is set. A frame no longer than the buffer sets no error.
- R7: The final write of each frame goes to descriptor word 0 with the value length<<16 | error. This places the length in bits 29:16 and clears bit 31. No data write follows it.
- R8: If word 1 bit 14 is set, the next descriptor address is word 3. Otherwise it is the current address + 16.
- R9: Completion sets status bit 0 (frame received) and bit 2 (summary). `irq` follows bit 2.
- R10: Writing the status register (register 2) clears each bit written as one and keeps bits written as zero. A set event in the same cycle as a clear wins.
- R11: A memory request holds its address, direction and data until `mem_ack`. `s_ready` is low while a request is pending, and no byte is lost across memory stalls.
- R12: Writing register 1 stores the ring base, which reads back, and moves the descriptor pointer there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 enable, 1 ring base, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte is the last of its frame |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| irq | output | 1 | Receive interrupt (status summary bit) |

## Verification
Two functions can land in the same cycle: the status set from an acknowledged descriptor write-back, and a software write that clears that same bit. The bench watches the memory port for the write-back request to descriptor word 0 while the memory model is not stalling. In that same cycle it issues a write-one-to-clear of bit 0, then reads the status and requires bit 0 still set. Sweeps over frame length 1..10 against buffer sizes 5 and 8, some with random memory stalls, cover both exact fits and truncation with partial final words.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int DESC_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int LEN_LSB   = 16;
  localparam int LEN_BITS  = 14;
  localparam int CHAIN_BIT = 14;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_RECV,
    ST_WDATA,
    ST_DROP,
    ST_WB
  } rxr_state_e;

  // One-hot byte lane for a byte position within a 32-bit word.
  function automatic logic [3:0] lane_bit(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

  // Descriptor word 0 as written back on completion: ownership bit zero.
  function automatic logic [DESC_W-1:0] wb_word(input logic [LEN_BITS-1:0] len,
                                                 input logic err);
    logic [DESC_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_BITS] = len;
    w[0] = err;
    w[OWN_BIT] = 1'b0;
    return w;
  endfunction

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          evt_done,
  input  logic          evt_nobuf,
  output logic          go,
  output logic          base_load,
  output logic [AW-1:0] base_val,
  output logic          irq
);
  localparam int STS_W = 3;

  logic            go_q;
  logic [AW-1:0]   base_q;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] sts_clr;
  logic [STS_W-1:0] sts_set;

  assign sts_clr   = (reg_we && reg_addr == 2'd2) ? reg_wdata[STS_W-1:0] : '0;
  assign sts_set   = {evt_done, evt_nobuf, evt_done};
  assign base_load = reg_we && reg_addr == 2'd1;
  assign base_val  = reg_wdata[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      base_q <= '0;
      sts_q  <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) go_q <= reg_wdata[0];
      if (base_load) base_q <= base_val;
      sts_q <= (sts_q & ~sts_clr) | sts_set;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'd0, go_q};
      2'd1:    reg_rdata = 32'(base_q);
      2'd2:    reg_rdata = {{(32-STS_W){1'b0}}, sts_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign go  = go_q;
  assign irq = sts_q[2];
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 14,
  parameter int SZW    = 13,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          base_load,
  input  logic [AW-1:0] base_val,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          evt_done,
  output logic          evt_nobuf,
  output logic          data_req,
  output logic          wb_req,
  output logic          idle
);
  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [AW-1:0] DSTEP = AW'(STRIDE);

  rxr_state_e    state;
  logic [AW-1:0] cur, nxt_ptr, buf_addr, wr_off;
  logic [LW-1:0] size, cnt;
  logic          chain, trunc, last_seen;
  logic [31:0]   wbuf;
  logic [3:0]    be;

  logic [1:0] lane;
  logic       take;
  logic [3:0] be_nx;
  logic       flush;

  assign lane  = cnt[1:0];
  assign take  = (state == ST_RECV) && s_valid && (cnt < size);
  assign be_nx = take ? (be | lane_bit(lane)) : be;
  assign flush = (state == ST_RECV) && s_valid &&
                 ((take && lane == 2'd3) || (s_last && be_nx != 4'd0));

  assign s_ready   = (state == ST_RECV) || (state == ST_DROP);
  assign data_req  = (state == ST_WDATA);
  assign wb_req    = (state == ST_WB);
  assign idle      = (state == ST_IDLE);
  assign evt_done  = (state == ST_WB) && mem_ack;
  assign evt_nobuf = (state == ST_DROP) && s_valid && s_last;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = 32'd0;
    mem_be    = 4'd0;
    case (state)
      ST_RD0:   begin mem_req = 1'b1; mem_addr = cur; end
      ST_RD1:   begin mem_req = 1'b1; mem_addr = cur + WSTEP; end
      ST_RD2:   begin mem_req = 1'b1; mem_addr = cur + (WSTEP << 1); end
      ST_RD3:   begin mem_req = 1'b1; mem_addr = cur + (WSTEP * AW'(3)); end
      ST_WDATA: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = buf_addr + wr_off; mem_wdata = wbuf; mem_be = be;
      end
      ST_WB:    begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur;
        mem_wdata = wb_word(cnt, trunc); mem_be = 4'hF;
      end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      nxt_ptr   <= '0;
      buf_addr  <= '0;
      wr_off    <= '0;
      size      <= '0;
      cnt       <= '0;
      chain     <= 1'b0;
      trunc     <= 1'b0;
      last_seen <= 1'b0;
      wbuf      <= '0;
      be        <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go && s_valid) begin
          state <= ST_RD0;
          cnt <= '0; trunc <= 1'b0; last_seen <= 1'b0;
          be <= '0; wbuf <= '0; wr_off <= '0;
        end
        ST_RD0: if (mem_ack) state <= mem_rdata[OWN_BIT] ? ST_RD1 : ST_DROP;
        ST_RD1: if (mem_ack) begin
          size  <= LW'(mem_rdata[SZW-1:0]);
          chain <= mem_rdata[CHAIN_BIT];
          state <= ST_RD2;
        end
        ST_RD2: if (mem_ack) begin
          buf_addr <= mem_rdata[AW-1:0];
          state    <= ST_RD3;
        end
        ST_RD3: if (mem_ack) begin
          nxt_ptr <= mem_rdata[AW-1:0];
          state   <= ST_RECV;
        end
        ST_RECV: if (s_valid) begin
          if (take) begin
            wbuf[{lane, 3'b000} +: 8] <= s_data;
            cnt <= cnt + LW'(1);
          end else begin
            trunc <= 1'b1;
          end
          be <= be_nx;
          if (s_last) last_seen <= 1'b1;
          if (flush) state <= ST_WDATA;
          else if (s_last) state <= ST_WB;
        end
        ST_WDATA: if (mem_ack) begin
          wr_off <= wr_off + WSTEP;
          be     <= '0;
          wbuf   <= '0;
          state  <= last_seen ? ST_WB : ST_RECV;
        end
        ST_WB: if (mem_ack) begin
          cur   <= chain ? nxt_ptr : cur + DSTEP;
          state <= ST_IDLE;
        end
        ST_DROP: if (s_valid && s_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (base_load) cur <= base_val;
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int AW     = 32,
  parameter int LW     = 14,
  parameter int SZW    = 13,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          irq
);
  logic          go;
  logic          base_load;
  logic [AW-1:0] base_val;
  logic          evt_done;
  logic          evt_nobuf;
  logic          data_req;
  logic          wb_req;
  logic          eng_idle;

  rxr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done(evt_done), .evt_nobuf(evt_nobuf),
    .go(go), .base_load(base_load), .base_val(base_val), .irq(irq)
  );

  rxr_engine #(.AW(AW), .LW(LW), .SZW(SZW), .STRIDE(STRIDE)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .go(go), .base_load(base_load), .base_val(base_val),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evt_done(evt_done), .evt_nobuf(evt_nobuf),
    .data_req(data_req), .wb_req(wb_req), .idle(eng_idle)
  );
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        eng_idle,
  input logic        s_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        data_req,
  input logic        wb_req,
  input logic        irq
);
  a_r7_own_released: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (mem_we && !mem_wdata[31] && mem_be == 4'hF));

  a_r5_be_packed: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r11_no_byte_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_ready);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wb_req && mem_ack));

  a_r2_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !go) |=> !mem_req);
endmodule

bind rxring_writer rxr_checker u_rxr_checker (
  .clk(clk), .rst_n(rst_n), .go(go), .eng_idle(eng_idle), .s_ready(s_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_be(mem_be), .data_req(data_req), .wb_req(wb_req),
  .irq(irq)
);

// File: tb/tb_rxring_writer.sv
`timescale 1ns/1ps
module tb_rxring_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        s_valid, s_last, s_ready, irq;
  logic [7:0]  s_data;

  logic [31:0] mem [0:1023];
  logic        stall = 1'b0;
  logic        stall_mode;
  logic [15:0] lfsr = 16'hACE1;
  int          wr_count = 0;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  rxring_writer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .irq(irq)
  );

  assign mem_ack   = mem_req && !stall;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      wr_count <= wr_count + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      stall = stall_mode ? lfsr[0] : 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + 1) & 255);
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pat(seed, i); s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_sts(input logic [31:0] mask, input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    v = 0;
    while ((v & mask) == 0 && n < 400) begin
      reg_read(2'd2, v);
      n++;
    end
    if ((v & mask) == 0) begin
      fails++;
      $display("FAIL %s status timeout actual=%0h expected_mask=%0h", tag, v, mask);
    end
  endtask

  task automatic prep_desc(input int d, input bit own, input int size, input bit chain,
                           input int bufa, input int nxt);
    mem[d >> 2]       = own ? 32'h8000_0000 : 32'h0;
    mem[(d >> 2) + 1] = (chain ? 32'h4000 : 32'h0) | 32'(size);
    mem[(d >> 2) + 2] = 32'(bufa);
    mem[(d >> 2) + 3] = 32'(nxt);
    for (int w = 0; w < 4; w++) mem[(bufa >> 2) + w] = 32'hA5A5_A5A5;
  endtask

  task automatic check_frame(input string tag, input int d, input int bufa,
                             input int len, input int size, input int seed);
    int el;
    logic [31:0] exp0;
    logic [7:0] got, exb, bad_got, bad_exp;
    bit bad;
    el = (len < size) ? len : size;
    exp0 = (32'(el) << 16) | ((len > size) ? 32'd1 : 32'd0);
    chk({tag, " R7 R6 write-back word"}, mem[d >> 2], exp0);
    bad = 0; bad_got = 0; bad_exp = 0;
    for (int b = 0; b < 16; b++) begin
      got = mem[(bufa + b) >> 2][(b % 4) * 8 +: 8];
      exb = (b < el) ? pat(seed, b) : 8'hA5;
      if (got !== exb && !bad) begin bad = 1; bad_got = got; bad_exp = exb; end
    end
    chk({tag, " R5 R6 buffer bytes"}, {24'd0, bad_got}, {24'd0, bad_exp});
  endtask

  initial begin
    logic [31:0] v;
    int n;
    int wc;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
    s_valid = 1'b0; s_data = 8'd0; s_last = 1'b0; stall_mode = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, v); chk("R1 enable reg", v, 0);
    reg_read(2'd1, v); chk("R1 base reg", v, 0);
    reg_read(2'd2, v); chk("R1 status reg", v, 0);
    chk("R1 outputs idle", {29'd0, s_ready, mem_req, irq}, 0);

    // R2 disabled engine ignores stream
    n = 0;
    s_valid = 1'b1; s_data = 8'h11; s_last = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (s_ready || mem_req) n++;
    end
    s_valid = 1'b0;
    chk("R2 no activity while disabled", 32'(n), 0);

    // R12 base register
    reg_write(2'd1, 32'h100);
    reg_read(2'd1, v); chk("R12 base readback", v, 32'h100);
    reg_write(2'd0, 32'd1);

    // R3 R5 R6 R8 R9 R10 R11 sweep over chained ring of 4 descriptors
    n = 0;
    for (int sz = 5; sz <= 8; sz += 3) begin
      for (int len = 1; len <= 10; len++) begin
        int slot, d, bufa;
        slot = n % 4;
        d = 32'h100 + slot * 32'h40;
        bufa = 32'h800 + slot * 32'h20;
        prep_desc(d, 1, sz, 1, bufa, 32'h100 + ((slot + 1) % 4) * 32'h40);
        stall_mode = n[0];
        send_frame(len, n);
        wait_sts(32'h1, "R9 completion");
        stall_mode = 1'b0;
        check_frame($sformatf("sweep size=%0d len=%0d R3 R8 R11", sz, len), d, bufa, len, sz, n);
        reg_read(2'd2, v); chk("R9 status after frame", v, 32'h5);
        chk("R9 irq high", {31'd0, irq}, 1);
        reg_write(2'd2, 32'h7);
        reg_read(2'd2, v); chk("R10 status cleared", v, 0);
        chk("R10 irq low after clear", {31'd0, irq}, 0);
        n++;
      end
    end

    // R4 host-owned descriptor drops frame (pointer is back at 0x100)
    prep_desc(32'h100, 0, 8, 1, 32'h800, 32'h140);
    mem[32'h100 >> 2] = 32'h0000_0000;
    wc = wr_count;
    send_frame(4, 77);
    wait_sts(32'h2, "R4 drop");
    reg_read(2'd2, v); chk("R4 status no-buffer only", v, 32'h2);
    chk("R4 no memory writes", 32'(wr_count - wc), 0);
    chk("R4 descriptor untouched", mem[32'h100 >> 2], 0);
    chk("R4 buffer untouched", mem[32'h800 >> 2], 32'hA5A5_A5A5);
    reg_write(2'd2, 32'h2);
    mem[32'h100 >> 2] = 32'h8000_0000;
    send_frame(3, 78);
    wait_sts(32'h1, "R4 retry");
    check_frame("R4 same descriptor reused", 32'h100, 32'h800, 3, 8, 78);
    reg_write(2'd2, 32'h7);

    // R8 unchained descriptor steps by 16; word3 points at a host-owned trap
    prep_desc(32'h100, 0, 8, 1, 32'h800, 32'h100);
    reg_write(2'd1, 32'h300);
    prep_desc(32'h300, 1, 8, 0, 32'h900, 32'h100);
    prep_desc(32'h310, 1, 8, 1, 32'h920, 32'h300);
    send_frame(6, 90);
    wait_sts(32'h1, "R8 first");
    check_frame("R8 unchained first", 32'h300, 32'h900, 6, 8, 90);
    reg_write(2'd2, 32'h7);
    send_frame(2, 91);
    wait_sts(32'h1, "R8 second");
    check_frame("R8 stepped to +16", 32'h310, 32'h920, 2, 8, 91);
    reg_read(2'd2, v); chk("R8 no drop on step", v, 32'h5);
    reg_write(2'd2, 32'h7);

    // R10 clear and set in the same cycle: set wins (pointer back at 0x300)
    prep_desc(32'h300, 1, 8, 1, 32'h900, 32'h300);
    fork
      send_frame(2, 95);
      begin
        @(negedge clk);
        while (!(mem_req && mem_we && mem_ack && mem_addr == 32'h300)) @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 1'b0;
      end
    join
    reg_read(2'd2, v); chk("R10 set wins over same-cycle clear", v, 32'h5);
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R10 zero write keeps bits", v, 32'h5);
    reg_write(2'd2, 32'h4);
    reg_read(2'd2, v); chk("R10 partial clear", v, 32'h1);
    chk("R9 irq follows summary", {31'd0, irq}, 0);
    check_frame("R10 collision frame", 32'h300, 32'h900, 2, 8, 95);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule